// File: doc/BRIEF.md
# Smart Card Receive Request Controller

This block is the receive half of an asynchronous smart card serial port. It watches a serial line that idles high, finds each character frame, checks its even parity and decides, once per character, whether to hand the byte to software or a DMA channel, or to record an error. In T=0 mode a character with bad parity is never delivered. Instead the block emits a one-cycle retransmit request that an external error-signal driver uses to make the card send the character again. This keeps a DMA byte count equal to the number of good characters.

Sticky flags record parity, overrun, wait-time and received-error-signal conditions. Only their own software clear strobes remove them. A receive-data-full flag drives a level DMA request. A read strobe or a DMA acknowledge clears that flag. The interrupt enable and an error-only mask decide which interrupt lines go out.

Top module: `scrx_req_ctrl`

## Requirements
- R1: After reset all flags, the data byte and every request output are 0.
- R2: A frame is a low start bit, 8 data bits least significant first, and a parity bit giving even parity over data and parity. Each bit lasts `div_i` cycles. The line is sampled `div_i/2` cycles into each bit, counting from the edge that first sees the line low. A good character that arrives while `rdf_o` is 0 loads `data_o` and sets `rdf_o` on the edge of the parity sample.
- R3: `dma_req_o` is high exactly while `rdf_o` is 1. A one-cycle `rd_i` or `dma_ack_i` clears `rdf_o`.
- R4: In T=0 mode (`t0_i`=1), a character with bad parity produces a `retx_o` pulse one cycle long, in the cycle after the parity sample.
- R5: A parity failure sets `per_o` in both modes. Outside T=0 mode the byte is still delivered as in R2 and R7.
- R6: In T=0 mode a character with bad parity leaves `rdf_o`, `dma_req_o` and `data_o` unchanged.
- R7: A delivered character that completes while `rdf_o` is 1 sets `ovr_o` and is discarded, and `data_o` keeps the old byte.
- R8: `wt_o` is set when more than `wait_lim_i` cycles pass after a start detection with no new start detection.
- R9: A pulse on `err_sig_i` sets `ers_o`.
- R10: `per_o`, `ovr_o`, `wt_o` and `ers_o` stay set until their own clear strobe arrives. A new setting event in the same cycle wins over the clear.
- R11: `rx_irq_o` = `rie_i` and not `err_only_i` and `rdf_o`.
- R12: `err_irq_o` = `rie_i` and (any of `per_o`, `ovr_o`, `wt_o`, `ers_o`).
- R13: If the start bit is high at its sample point, the frame is abandoned. With `en_i` low the receiver stays idle and the wait timer is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| en_i | input | 1 | receiver enable |
| rx_i | input | 1 | serial data, synchronous to clk, idles high |
| t0_i | input | 1 | T=0 protocol mode |
| div_i | input | DIV_W | cycles per bit (at least 2) |
| wait_lim_i | input | WT_W | wait-time limit in cycles |
| rie_i | input | 1 | receive interrupt enable |
| err_only_i | input | 1 | mask data interrupts, keep error interrupts |
| err_sig_i | input | 1 | pulse: error signal seen on the line |
| rd_i | input | 1 | pulse: software read of the data byte |
| dma_ack_i | input | 1 | pulse: DMA has taken the byte |
| clr_per_i | input | 1 | clear parity error flag |
| clr_ovr_i | input | 1 | clear overrun flag |
| clr_wt_i | input | 1 | clear wait-time flag |
| clr_ers_i | input | 1 | clear error-signal flag |
| data_o | output | 8 | received byte |
| rdf_o | output | 1 | receive data full |
| per_o | output | 1 | parity error flag |
| ovr_o | output | 1 | overrun flag |
| wt_o | output | 1 | wait-time error flag |
| ers_o | output | 1 | error-signal received flag |
| dma_req_o | output | 1 | DMA request for receive data |
| rx_irq_o | output | 1 | receive data interrupt |
| err_irq_o | output | 1 | error interrupt |
| retx_o | output | 1 | retransmit request pulse |

## Verification
Every character result lands on the clock edge that samples the parity bit. That edge comes `div_i/2 + 9*div_i` cycles after the edge that detected the start, so the flags, `data_o` and `dma_req_o` change there and `retx_o` is high for the following cycle. A strobe (`rd_i`, `dma_ack_i`, a clear, `err_sig_i`) takes effect on the next edge. A wait-time error appears on the edge `wait_lim_i + 1` cycles after the last detection. The interrupt outputs follow their inputs in the same cycle. The bench keeps a behavioural model that counts cycles from each detection in plain integers. It drives inputs just after a rising edge and compares every output with the model at the falling edge, so each result is checked in the cycle it is due and in every other cycle as well.

// File: rtl/scrx_pkg.sv
package scrx_pkg;

  typedef struct packed {
    logic [7:0] data;
    logic       par_err;
  } rx_char_t;

  // sample point inside a bit: half the bit length
  function automatic logic [15:0] half_of(input logic [15:0] bit_len);
    return bit_len >> 1;
  endfunction

  // even parity: data bits plus parity bit carry an even number of ones
  function automatic logic par_good(input logic [7:0] d, input logic p);
    return ~(^{d, p});
  endfunction

endpackage

// File: rtl/scrx_sampler.sv
module scrx_sampler
  import scrx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             rx_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             det_o,
  output logic             done_o,
  output rx_char_t         char_o
);
  localparam int BITS = 10;
  localparam int BN_W = $clog2(BITS);

  logic             act_q;
  logic [DIV_W-1:0] ph_q;
  logic [BN_W-1:0]  bit_q;
  logic [8:0]       sh_q;
  logic             smp_w;

  assign det_o  = en_i && !act_q && !rx_i;
  assign smp_w  = act_q && (16'(ph_q) == half_of(16'(div_i)));
  assign done_o = smp_w && (bit_q == BN_W'(BITS - 1));
  assign char_o.data    = sh_q[8:1];
  assign char_o.par_err = !par_good(sh_q[8:1], rx_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= '0;
      bit_q <= '0;
      sh_q  <= '0;
    end else if (!en_i) begin
      act_q <= 1'b0;
    end else if (det_o) begin
      act_q <= 1'b1;
      ph_q  <= DIV_W'(1);
      bit_q <= '0;
    end else if (act_q) begin
      ph_q <= (ph_q == div_i - 1'b1) ? '0 : ph_q + 1'b1;
      if (smp_w) begin
        if (bit_q == '0 && rx_i) begin
          act_q <= 1'b0;
        end else begin
          if (bit_q != '0) sh_q <= {rx_i, sh_q[8:1]};
          bit_q <= bit_q + 1'b1;
          if (bit_q == BN_W'(BITS - 1)) act_q <= 1'b0;
        end
      end
    end
  end

  // R13
  start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && smp_w && bit_q == '0 && rx_i) |=> !act_q);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !act_q);

endmodule

// File: rtl/scrx_wait_tmr.sv
module scrx_wait_tmr #(
  parameter int WT_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            det_i,
  input  logic [WT_W-1:0] lim_i,
  output logic            wt_set_o
);
  logic [WT_W-1:0] cnt_q;
  logic            arm_q;

  assign wt_set_o = en_i && arm_q && (cnt_q == lim_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      arm_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      arm_q <= 1'b0;
    end else if (det_i) begin
      cnt_q <= '0;
      arm_q <= 1'b1;
    end else if (arm_q) begin
      if (cnt_q == lim_i) arm_q <= 1'b0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8
  wt_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wt_set_o && !det_i) |=> !wt_set_o);

endmodule

// File: rtl/scrx_flags.sv
module scrx_flags
  import scrx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     done_i,
  input  rx_char_t char_i,
  input  logic     t0_i,
  input  logic     rd_i,
  input  logic     dma_ack_i,
  input  logic     err_sig_i,
  input  logic     wt_set_i,
  input  logic     clr_per_i,
  input  logic     clr_ovr_i,
  input  logic     clr_wt_i,
  input  logic     clr_ers_i,
  output logic [7:0] data_o,
  output logic     rdf_o,
  output logic     per_o,
  output logic     ovr_o,
  output logic     wt_o,
  output logic     ers_o,
  output logic     retx_o
);
  logic rdf_eff_w, t0_bad_w, deliver_w, load_w, ovr_hit_w;

  assign rdf_eff_w = rdf_o && !(rd_i || dma_ack_i);
  assign t0_bad_w  = done_i && t0_i && char_i.par_err;
  assign deliver_w = done_i && !t0_bad_w;
  assign load_w    = deliver_w && !rdf_eff_w;
  assign ovr_hit_w = deliver_w && rdf_eff_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      rdf_o  <= 1'b0;
      per_o  <= 1'b0;
      ovr_o  <= 1'b0;
      wt_o   <= 1'b0;
      ers_o  <= 1'b0;
      retx_o <= 1'b0;
    end else begin
      if (load_w) data_o <= char_i.data;
      rdf_o  <= rdf_eff_w || load_w;
      per_o  <= (per_o && !clr_per_i) || (done_i && char_i.par_err);
      ovr_o  <= (ovr_o && !clr_ovr_i) || ovr_hit_w;
      wt_o   <= (wt_o && !clr_wt_i) || wt_set_i;
      ers_o  <= (ers_o && !clr_ers_i) || err_sig_i;
      retx_o <= t0_bad_w;
    end
  end

  // R6
  t0_no_rdf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t0_bad_w && !rdf_o) |=> !rdf_o);

  // R7
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_hit_w |=> (ovr_o && $stable(data_o) && rdf_o));

  // R10
  per_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_o && !clr_per_i) |=> per_o);

  // R4
  retx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retx_o |=> !retx_o);

  // R3
  rdf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdf_o) |-> $past(done_i));

endmodule

// File: rtl/scrx_req_ctrl.sv
module scrx_req_ctrl
  import scrx_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int WT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             rx_i,
  input  logic             t0_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [WT_W-1:0]  wait_lim_i,
  input  logic             rie_i,
  input  logic             err_only_i,
  input  logic             err_sig_i,
  input  logic             rd_i,
  input  logic             dma_ack_i,
  input  logic             clr_per_i,
  input  logic             clr_ovr_i,
  input  logic             clr_wt_i,
  input  logic             clr_ers_i,
  output logic [7:0]       data_o,
  output logic             rdf_o,
  output logic             per_o,
  output logic             ovr_o,
  output logic             wt_o,
  output logic             ers_o,
  output logic             dma_req_o,
  output logic             rx_irq_o,
  output logic             err_irq_o,
  output logic             retx_o
);
  logic     det_w, done_w, wt_set_w;
  rx_char_t char_w;

  scrx_sampler #(.DIV_W(DIV_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .rx_i(rx_i), .div_i(div_i),
    .det_o(det_w), .done_o(done_w), .char_o(char_w)
  );

  scrx_wait_tmr #(.WT_W(WT_W)) u_wt (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .det_i(det_w),
    .lim_i(wait_lim_i), .wt_set_o(wt_set_w)
  );

  scrx_flags u_flg (
    .clk(clk), .rst_n(rst_n), .done_i(done_w), .char_i(char_w), .t0_i(t0_i),
    .rd_i(rd_i), .dma_ack_i(dma_ack_i), .err_sig_i(err_sig_i),
    .wt_set_i(wt_set_w), .clr_per_i(clr_per_i), .clr_ovr_i(clr_ovr_i),
    .clr_wt_i(clr_wt_i), .clr_ers_i(clr_ers_i), .data_o(data_o),
    .rdf_o(rdf_o), .per_o(per_o), .ovr_o(ovr_o), .wt_o(wt_o),
    .ers_o(ers_o), .retx_o(retx_o)
  );

  assign dma_req_o = rdf_o;
  assign rx_irq_o  = rie_i && !err_only_i && rdf_o;
  assign err_irq_o = rie_i && (per_o || ovr_o || wt_o || ers_o);

  // R4
  retx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retx_o |-> ($past(done_w) && $past(t0_i) && per_o));

  // R9
  ers_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_sig_i |=> ers_o);

  // R12
  err_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq_o |-> rie_i);

endmodule

// File: tb/scrx_req_ctrl_tb.sv
module scrx_req_ctrl_tb;
  logic       clk = 0, rst_n = 0;
  logic       en = 0, rx = 1, t0 = 0, rie = 0, eo = 0, esig = 0, rd = 0, ack = 0;
  logic       cper = 0, covr = 0, cwt = 0, cers = 0;
  logic [7:0] div = 8;
  logic [15:0] lim = 300;
  logic [7:0] data;
  logic rdf, per, ovr, wt, ers, dreq, rxirq, eirq, retx;
  int n_chk = 0, n_fail = 0;
  bit chk_on = 0;

  always #10 clk = ~clk;

  scrx_req_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .rx_i(rx), .t0_i(t0), .div_i(div),
    .wait_lim_i(lim), .rie_i(rie), .err_only_i(eo), .err_sig_i(esig),
    .rd_i(rd), .dma_ack_i(ack), .clr_per_i(cper), .clr_ovr_i(covr),
    .clr_wt_i(cwt), .clr_ers_i(cers), .data_o(data), .rdf_o(rdf),
    .per_o(per), .ovr_o(ovr), .wt_o(wt), .ers_o(ers), .dma_req_o(dreq),
    .rx_irq_o(rxirq), .err_irq_o(eirq), .retx_o(retx)
  );

  // behavioural reference model
  int cyc = 0, m_st = 0, m_last = 0;
  bit m_act = 0, m_arm = 0;
  bit [9:0] m_b;
  bit [7:0] m_data;
  bit m_rdf, m_per, m_ovr, m_wt, m_ers, m_retx;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_act = 0; m_arm = 0; m_data = 0; m_rdf = 0; m_per = 0; m_ovr = 0;
      m_wt = 0; m_ers = 0; m_retx = 0;
    end else begin
      bit det, done, pe, rdf_e;
      det = 0; done = 0; pe = 0;
      rdf_e = m_rdf && !(rd || ack);
      if (cper) m_per = 0;
      if (covr) m_ovr = 0;
      if (cwt)  m_wt = 0;
      if (cers) m_ers = 0;
      m_retx = 0;
      if (!en) begin
        m_act = 0; m_arm = 0;
      end else if (!m_act) begin
        if (!rx) begin m_act = 1; m_st = cyc; det = 1; end
      end else begin
        int j, n;
        j = cyc - m_st;
        if (j % int'(div) == int'(div) / 2) begin
          n = j / int'(div);
          if (n == 0 && rx) m_act = 0;
          else begin
            m_b[n] = rx;
            if (n == 9) begin m_act = 0; done = 1; end
          end
        end
      end
      if (en && m_arm && (cyc - m_last - 1 == int'(lim))) begin m_wt = 1; m_arm = 0; end
      if (det) begin m_last = cyc; m_arm = 1; end
      if (esig) m_ers = 1;
      if (done) begin
        pe = ^m_b[9:1];
        if (pe) m_per = 1;
        if (t0 && pe) m_retx = 1;
        else if (rdf_e) m_ovr = 1;
        else begin m_data = m_b[8:1]; rdf_e = 1; end
      end
      m_rdf = rdf_e;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (chk_on) begin
    chk("R2 data_o", 32'(data), 32'(m_data));
    chk("R2 rdf_o", 32'(rdf), 32'(m_rdf));
    chk("R3 dma_req_o", 32'(dreq), 32'(m_rdf));
    chk("R5 R10 per_o", 32'(per), 32'(m_per));
    chk("R7 R10 ovr_o", 32'(ovr), 32'(m_ovr));
    chk("R8 R10 wt_o", 32'(wt), 32'(m_wt));
    chk("R9 R10 ers_o", 32'(ers), 32'(m_ers));
    chk("R4 retx_o", 32'(retx), 32'(m_retx));
    chk("R11 rx_irq_o", 32'(rxirq), 32'(rie && !eo && m_rdf));
    chk("R12 err_irq_o", 32'(eirq), 32'(rie && (m_per || m_ovr || m_wt || m_ers)));
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic send(input logic [7:0] b, input bit bad);
    logic [9:0] f;
    f = {(^b) ^ bad, b, 1'b0};
    for (int i = 0; i < 10; i++) begin rx = f[i]; tick(int'(div)); end
    rx = 1; tick(2 * int'(div));
  endtask

  task automatic pulse(ref logic s);
    s = 1; tick(); s = 0; tick();
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick();
    chk_on = 1;
    // R1 reset state
    chk("R1 reset", {data, rdf, per, ovr, wt, ers, dreq, rxirq, eirq, retx}, 0);
    en = 1; rie = 1;
    send(8'hA5, 0);
    chk("R2 byte A5", 32'(data), 32'hA5);
    chk("R11 rx_irq", 32'(rxirq), 1);
    pulse(rd);
    chk("R3 read clears", 32'(dreq), 0);
    send(8'h3C, 0);
    pulse(ack);
    chk("R3 ack clears", 32'(rdf), 0);
    send(8'h11, 0);
    send(8'h22, 0);
    chk("R7 overrun", 32'(ovr), 1);
    chk("R7 old byte kept", 32'(data), 32'h11);
    pulse(rd); pulse(covr);
    send(8'h5A, 1);
    chk("R5 delivered with per", {24'h0, data}, 32'h5A);
    chk("R5 per", 32'(per), 1);
    pulse(rd); pulse(cper);
    t0 = 1;
    send(8'h77, 1);
    chk("R6 no rdf", 32'(rdf), 0);
    chk("R6 data kept", 32'(data), 32'h5A);
    send(8'h77, 0);
    chk("R2 t0 good", 32'(data), 32'h77);
    eo = 1; tick();
    chk("R11 masked", 32'(rxirq), 0);
    pulse(rd);
    pulse(esig);
    chk("R9 ers", 32'(ers), 1);
    chk("R12 err_irq", 32'(eirq), 1);
    tick(400);
    chk("R8 wait error", 32'(wt), 1);
    pulse(cper); pulse(covr); pulse(cwt); pulse(cers);
    // false start
    rx = 0; tick(); rx = 1; tick(40);
    chk("R13 glitch ignored", 32'(rdf), 0);
    // enable dropped mid frame
    rx = 0; tick(30); en = 0; tick(); rx = 1; tick(100); en = 1; tick(20);
    chk("R13 disabled", 32'(rdf), 0);
    div = 5; t0 = 0;
    send(8'h0F, 0);
    chk("R2 div5", 32'(data), 32'h0F);
    send(8'hF0, 0);
    pulse(ack);
    send(8'hC3, 1);
    tick(10);
    chk_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule